// File: doc/BRIEF.md
# Accumulator ALU with Skip Decision

This block is the 8-bit arithmetic and logic stage of an accumulator machine. Each cycle it may take one operation together with its operands: the accumulator, a memory or immediate operand, the low nibble of the B pointer register and a register-file operand. It also takes the current carry and half-carry flags. One clock later it presents the result, a write strobe for that result, the next carry and half-carry values, and a skip-next decision for the instruction sequencer.

Arithmetic and logic operations write a result and never skip. Test and compare operations write nothing and leave both flags as they were; their only output is the skip decision. The compares are phrased as "execute the next instruction if the condition holds", so the block asserts skip when the condition fails. The decrement-and-test operation both writes back and may skip. Operand fetch, memory write-back and the sequencer that acts on the skip belong to the surrounding core.

Top module: `alu_skip_core`

## Requirements
- R1: Operation code 0 (plain add) writes acc + operand, modulo 256, and returns carry and half-carry unchanged.
- R2: Operation code 1 (add with carry) writes acc + operand + carry. Carry-out is the carry out of bit 7 and half-carry-out is the carry out of bit 3. The operation does not skip.
- R3: Operation code 2 (subtract with carry) writes acc - operand - (1 - carry), modulo 256. Carry-out is 1 when no borrow occurs across all 8 bits. Half-carry-out is 1 when no borrow occurs out of the low nibble.
- R4: Operation codes 3, 4 and 5 write acc AND, OR and XOR operand respectively, and return both flags unchanged.
- R5: Operation code 6 asserts skip exactly when (acc AND operand) is zero. It does not write, and both flags stay unchanged.
- R6: Operation codes 7 (equal) and 8 (not equal) assert skip when their condition on acc and operand is false. They do not write, and both flags stay unchanged.
- R7: Operation code 9 treats acc and operand as unsigned and asserts skip unless acc > operand. It does not write.
- R8: Operation code 10 compares the 4-bit B-nibble input with operand bits [3:0] only, and asserts skip when they are equal. Operand bits [7:4] have no effect.
- R9: Operation code 11 writes register operand - 1, modulo 256, and asserts skip exactly when that new value is zero. An input of 0 yields 0xFF without a skip.
- R10: Outputs change on the clock edge after the operation is accepted, with out_valid high for one cycle per accepted operation. out_result reads zero whenever out_wr is low. After reset all outputs are zero.
- R11: Operation codes 12 to 15 produce no write and no skip, and return both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Operation code |
| in_acc | input | 8 | Accumulator value |
| in_opnd | input | 8 | Memory or immediate operand |
| in_b_lo | input | 4 | Low nibble of the B pointer register |
| in_reg | input | 8 | Register-file operand for decrement-and-test |
| in_carry | input | 1 | Current carry flag |
| in_hcarry | input | 1 | Current half-carry flag |
| out_valid | output | 1 | Result of an accepted operation is present |
| out_result | output | 8 | Value to write back |
| out_carry | output | 1 | Next carry flag |
| out_hcarry | output | 1 | Next half-carry flag |
| out_wr | output | 1 | Write strobe for out_result |
| out_skip | output | 1 | Skip the next instruction |

## Verification
The bench targets the flag edges of subtraction. These are a zero operand with carry clear, equal operands with carry set, and a borrow out of the low nibble alone. A design that treats carry as an active-high borrow flips both flags and is off by one in the result. Unsigned greater-than is exercised with 0x80 against 0x7F, where a signed compare would skip wrongly. The B-nibble test uses operands whose upper bits differ from the nibble, which catches a full-width compare. The decrement cases hit inputs of 1 and 0, which separate testing the new value from testing the old one. Flag hold is checked on every compare and logic operation, so a design that lets those operations update carry or half-carry is reported.

// File: rtl/alu_skip_pkg.sv
package alu_skip_pkg;

  typedef enum logic [3:0] {
    OP_ADD      = 4'd0,
    OP_ADD_C    = 4'd1,
    OP_SUB_C    = 4'd2,
    OP_AND      = 4'd3,
    OP_OR       = 4'd4,
    OP_XOR      = 4'd5,
    OP_TST_ZERO = 4'd6,
    OP_CMP_EQ   = 4'd7,
    OP_CMP_NE   = 4'd8,
    OP_CMP_GT   = 4'd9,
    OP_CMP_BLO  = 4'd10,
    OP_DEC_Z    = 4'd11
  } alu_op_e;

endpackage

// File: rtl/alu_nib_adder.sv
module alu_nib_adder #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              hcout
);
  localparam int NUM_NIB = DATA_W / NIB_W;

  logic [NUM_NIB:0] chain;

  assign chain[0] = cin;

  // one slice per nibble; the carry between slice 0 and 1 is the half carry
  for (genvar g = 0; g < NUM_NIB; g++) begin : g_slice
    logic [NIB_W:0] part;
    assign part = {1'b0, a[g*NIB_W +: NIB_W]}
                + {1'b0, b[g*NIB_W +: NIB_W]}
                + {{NIB_W{1'b0}}, chain[g]};
    assign sum[g*NIB_W +: NIB_W] = part[NIB_W-1:0];
    assign chain[g+1]            = part[NIB_W];
  end

  assign hcout = chain[1];
  assign cout  = chain[NUM_NIB];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_skip_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_skip_eval.sv
module alu_skip_eval
  import alu_skip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic [NIB_W-1:0]  b_lo,
  input  logic [DATA_W-1:0] dec_val,
  output logic              skip
);
  logic masked_zero;
  logic same;
  logic acc_above;
  logic nib_same;

  assign masked_zero = ((acc & opnd) == '0);
  assign same        = (acc == opnd);
  assign acc_above   = (acc > opnd);
  assign nib_same    = (b_lo == opnd[NIB_W-1:0]);

  // compares name the condition under which the next instruction runs
  always_comb begin
    unique case (op)
      OP_TST_ZERO: skip = masked_zero;
      OP_CMP_EQ:   skip = !same;
      OP_CMP_NE:   skip = same;
      OP_CMP_GT:   skip = !acc_above;
      OP_CMP_BLO:  skip = nib_same;
      OP_DEC_Z:    skip = (dec_val == '0);
      default:     skip = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_skip_core.sv
module alu_skip_core
  import alu_skip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_acc,
  input  logic [DATA_W-1:0] in_opnd,
  input  logic [NIB_W-1:0]  in_b_lo,
  input  logic [DATA_W-1:0] in_reg,
  input  logic              in_carry,
  input  logic              in_hcarry,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry,
  output logic              out_hcarry,
  output logic              out_wr,
  output logic              out_skip
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  // reset synchronizer: assert asynchronously, release on clock
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  alu_op_e op;
  assign op = alu_op_e'(in_op);

  // adder operand selection
  logic              is_sub;
  logic              use_cin;
  logic [DATA_W-1:0] add_b;
  logic              add_cin;
  logic [DATA_W-1:0] add_sum;
  logic              add_cout;
  logic              add_hcout;

  assign is_sub  = (op == OP_SUB_C);
  assign use_cin = (op == OP_ADD_C) || is_sub;
  assign add_b   = is_sub ? ~in_opnd : in_opnd;
  assign add_cin = use_cin ? in_carry : 1'b0;

  alu_nib_adder #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_adder (
    .a     (in_acc),
    .b     (add_b),
    .cin   (add_cin),
    .sum   (add_sum),
    .cout  (add_cout),
    .hcout (add_hcout)
  );

  logic [DATA_W-1:0] logic_y;

  alu_bitwise #(.DATA_W(DATA_W)) u_logic (
    .op (op),
    .a  (in_acc),
    .b  (in_opnd),
    .y  (logic_y)
  );

  logic [DATA_W-1:0] dec_val;
  assign dec_val = in_reg - ONE;

  logic skip_n;

  alu_skip_eval #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_skip (
    .op      (op),
    .acc     (in_acc),
    .opnd    (in_opnd),
    .b_lo    (in_b_lo),
    .dec_val (dec_val),
    .skip    (skip_n)
  );

  // next-state
  logic [DATA_W-1:0] result_n;
  logic              wr_n;
  logic              carry_n;
  logic              hcarry_n;

  always_comb begin
    result_n = '0;
    wr_n     = 1'b0;
    carry_n  = in_carry;
    hcarry_n = in_hcarry;
    unique case (op)
      OP_ADD: begin
        result_n = add_sum;
        wr_n     = 1'b1;
      end
      OP_ADD_C, OP_SUB_C: begin
        result_n = add_sum;
        wr_n     = 1'b1;
        carry_n  = add_cout;
        hcarry_n = add_hcout;
      end
      OP_AND, OP_OR, OP_XOR: begin
        result_n = logic_y;
        wr_n     = 1'b1;
      end
      OP_DEC_Z: begin
        result_n = dec_val;
        wr_n     = 1'b1;
      end
      default: ;
    endcase
  end

  // registers, data captured only when an operation is accepted
  logic              valid_q;
  logic [DATA_W-1:0] result_q;
  logic              wr_q;
  logic              carry_q;
  logic              hcarry_q;
  logic              skip_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      wr_q     <= 1'b0;
      carry_q  <= 1'b0;
      hcarry_q <= 1'b0;
      skip_q   <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        result_q <= result_n;
        wr_q     <= wr_n;
        carry_q  <= carry_n;
        hcarry_q <= hcarry_n;
        skip_q   <= skip_n;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_result = result_q;
  assign out_wr     = wr_q;
  assign out_carry  = carry_q;
  assign out_hcarry = hcarry_q;
  assign out_skip   = skip_q;

  // assertions
  AST_ADD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && (in_op == 4'd0) |=> out_carry == $past(in_carry) && out_hcarry == $past(in_hcarry)); // R1

  AST_ARITH_NEVER_SKIPS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && (in_op <= 4'd5) |=> out_wr && !out_skip); // R2

  AST_LOGIC_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && (in_op >= 4'd3) && (in_op <= 4'd5) |=> out_carry == $past(in_carry) && out_hcarry == $past(in_hcarry)); // R4

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && (in_op >= 4'd6) && (in_op <= 4'd10) |=> !out_wr && out_carry == $past(in_carry) && out_hcarry == $past(in_hcarry)); // R6

  AST_NIBBLE_MATCH_SKIPS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && (in_op == 4'd10) && (in_b_lo == in_opnd[NIB_W-1:0]) |=> out_skip); // R8

  AST_DEC_SKIP_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && (in_op == 4'd11) |=> out_wr && (out_skip == (out_result == '0))); // R9

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid); // R10

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid); // R10

  AST_UNDEF_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid && (in_op >= 4'd12) |=> !out_wr && !out_skip); // R11
endmodule

// File: tb/alu_skip_core_tb_top.sv
module alu_skip_core_tb_top;

  typedef struct {
    logic [7:0] res;
    logic       wr;
    logic       c;
    logic       hc;
    logic       skip;
    string      req;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [3:0] in_op;
  logic [7:0] in_acc;
  logic [7:0] in_opnd;
  logic [3:0] in_b_lo;
  logic [7:0] in_reg;
  logic       in_carry;
  logic       in_hcarry;
  logic       out_valid;
  logic [7:0] out_result;
  logic       out_carry;
  logic       out_hcarry;
  logic       out_wr;
  logic       out_skip;

  int checks = 0;
  int errors = 0;
  int sent   = 0;
  int seen   = 0;
  bit done   = 0;
  exp_t q[$];

  alu_skip_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_acc(in_acc), .in_opnd(in_opnd), .in_b_lo(in_b_lo), .in_reg(in_reg),
    .in_carry(in_carry), .in_hcarry(in_hcarry), .out_valid(out_valid),
    .out_result(out_result), .out_carry(out_carry), .out_hcarry(out_hcarry),
    .out_wr(out_wr), .out_skip(out_skip)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model written from the requirements
  function automatic exp_t model(int op, int a, int b, int blo, int r, int c, int hc);
    exp_t e;
    int t;
    e.res = 8'h00; e.wr = 1'b0; e.skip = 1'b0;
    e.c = c[0]; e.hc = hc[0];
    case (op)
      0: begin e.res = 8'((a + b) % 256); e.wr = 1; e.req = "R1"; end
      1: begin
        t = a + b + c;
        e.res = 8'(t % 256); e.wr = 1;
        e.c = (t > 255); e.hc = ((a % 16) + (b % 16) + c) > 15; e.req = "R2";
      end
      2: begin
        t = a - b - (1 - c);
        e.res = 8'((t + 256) % 256); e.wr = 1;
        e.c = (t >= 0); e.hc = ((a % 16) - (b % 16) - (1 - c)) >= 0; e.req = "R3";
      end
      3: begin e.res = 8'(a & b); e.wr = 1; e.req = "R4"; end
      4: begin e.res = 8'(a | b); e.wr = 1; e.req = "R4"; end
      5: begin e.res = 8'(a ^ b); e.wr = 1; e.req = "R4"; end
      6: begin e.skip = ((a & b) == 0); e.req = "R5"; end
      7: begin e.skip = (a != b); e.req = "R6"; end
      8: begin e.skip = (a == b); e.req = "R6"; end
      9: begin e.skip = !(a > b); e.req = "R7"; end
      10: begin e.skip = (blo == (b % 16)); e.req = "R8"; end
      11: begin
        e.res = 8'((r + 255) % 256); e.wr = 1; e.skip = (e.res == 8'h00); e.req = "R9";
      end
      default: e.req = "R11";
    endcase
    return e;
  endfunction

  task automatic send(int op, int a, int b, int blo, int r, int c, int hc);
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'(op); in_acc = 8'(a); in_opnd = 8'(b);
    in_b_lo = 4'(blo); in_reg = 8'(r); in_carry = c[0]; in_hcarry = hc[0];
    q.push_back(model(op, a, b, blo, r, c, hc));
    sent++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      checks++;
      seen++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected out_valid, actual 1 expected 0");
      end else begin
        e = q.pop_front();
        if (out_result !== e.res || out_wr !== e.wr || out_carry !== e.c ||
            out_hcarry !== e.hc || out_skip !== e.skip) begin
          errors++;
          $display("FAIL %s: actual res=%h wr=%b c=%b hc=%b skip=%b expected res=%h wr=%b c=%b hc=%b skip=%b",
                   e.req, out_result, out_wr, out_carry, out_hcarry, out_skip,
                   e.res, e.wr, e.c, e.hc, e.skip);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lf;
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_acc = '0; in_opnd = '0;
    in_b_lo = '0; in_reg = '0; in_carry = 1'b0; in_hcarry = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    checks++;
    if ({out_valid, out_result, out_wr, out_carry, out_hcarry, out_skip} !== 13'd0) begin
      errors++;
      $display("FAIL R10: reset state actual %b expected 0",
               {out_valid, out_result, out_wr, out_carry, out_hcarry, out_skip});
    end

    // R1 plain add keeps flags
    send(0, 8'hFF, 8'h01, 0, 0, 1, 0);
    send(0, 8'h0F, 8'h01, 0, 0, 0, 1);
    // R2 add with carry
    send(1, 8'h0F, 8'h01, 0, 0, 0, 0);
    send(1, 8'hFF, 8'h00, 0, 0, 1, 0);
    send(1, 8'h12, 8'h34, 0, 0, 0, 1);
    // R3 subtract with carry, carry = no borrow
    send(2, 8'h10, 8'h01, 0, 0, 1, 1);
    send(2, 8'h00, 8'h01, 0, 0, 1, 1);
    send(2, 8'h05, 8'h05, 0, 0, 0, 1);
    send(2, 8'h05, 8'h05, 1, 0, 1, 0);
    send(2, 8'h00, 8'h00, 0, 0, 0, 0);
    idle(2);
    // R4 logic keeps flags
    send(3, 8'hF0, 8'h3C, 0, 0, 1, 1);
    send(4, 8'hF0, 8'h0C, 0, 0, 0, 1);
    send(5, 8'hAA, 8'hFF, 0, 0, 1, 0);
    // R5 AND test
    send(6, 8'hF0, 8'h0F, 0, 0, 1, 0);
    send(6, 8'hF1, 8'h01, 0, 0, 0, 1);
    // R6 equal / not equal
    send(7, 8'h42, 8'h42, 0, 0, 1, 1);
    send(7, 8'h42, 8'h43, 0, 0, 0, 0);
    send(8, 8'h42, 8'h42, 0, 0, 1, 0);
    send(8, 8'h42, 8'hC2, 0, 0, 0, 1);
    // R7 unsigned greater-than
    send(9, 8'h80, 8'h7F, 0, 0, 0, 0);
    send(9, 8'h7F, 8'h80, 0, 0, 1, 1);
    send(9, 8'h55, 8'h55, 0, 0, 0, 0);
    // R8 nibble test, upper operand bits ignored
    send(10, 8'h00, 8'hA5, 5, 0, 0, 0);
    send(10, 8'h00, 8'hA5, 6, 0, 1, 1);
    send(10, 8'h00, 8'h35, 5, 0, 1, 0);
    // R9 decrement-and-test
    send(11, 0, 0, 0, 8'h01, 0, 0);
    send(11, 0, 0, 0, 8'h00, 1, 1);
    send(11, 0, 0, 0, 8'h02, 0, 1);
    // R11 undefined codes
    send(12, 8'h11, 8'h22, 3, 8'h01, 1, 0);
    send(15, 8'h00, 8'h00, 0, 8'h01, 0, 1);
    idle(3);

    // sweep over all codes, LFSR-style stimulus
    lf = 32'h1ACE;
    for (int i = 0; i < 300; i++) begin
      lf = ((lf << 1) ^ (((lf >> 15) & 1) ? 32'h1021 : 0)) & 32'hFFFF;
      send(i % 16, lf % 256, (lf >> 8) % 256, (lf >> 3) % 16, (lf >> 5) % 256,
           (lf >> 2) & 1, (lf >> 7) & 1);
      if ((i % 37) == 0) idle(1);
    end
    idle(4);

    // R10 every accepted operation produced exactly one result
    checks++;
    if (seen != sent || q.size() != 0) begin
      errors++;
      $display("FAIL R10: results actual %0d expected %0d", seen, sent);
    end
    finish_run();
  end

endmodule